// File: doc/BRIEF.md
# Buffered Prescaled Timer Base

This block is the time base of a general timer. A 16-bit prescaler divides the system clock into counting ticks. A 16-bit counter advances on each tick, upward or downward. When an upward count passes its limit, or a downward count runs out, the counter produces an update event. At that event the counter restarts, the prescaler takes its new ratio, and a sticky status flag is set. If the interrupt enable is set, the flag raises an interrupt request.

Software sets up the block through single-cycle register writes. The prescaler ratio written by software always waits in a holding register. It reaches the divider only at the next update event. The limit value, called the period, can either act at once or wait for the next update event, as a control bit selects.

Run state and direction are held by a three-state controller. `ST_HALT` means no counting. `ST_UP` counts upward and `ST_DOWN` counts downward. Every control write picks the next state from its run and down bits:
- STOP leads to `ST_HALT` from any state when the run bit is 0.
- START_UP leads to `ST_UP` when run is 1 and down is 0. From `ST_DOWN` this same transition is a reversal.
- START_DOWN leads to `ST_DOWN` when run is 1 and down is 1. From `ST_UP` this same transition is a reversal.
- Any other cycle keeps the current state (HOLD).

Top module: `tmr_base`

## Requirements
- R1: After reset the controller is in `ST_HALT` and counts upward once started. `count` is 0, `upd_evt` is 0 and `irq` is 0. The prescaler ratio is 0, the period is 0xFFFF and all control bits are 0.
- R2: A write to address 0 sets the control bits: bit 0 run, bit 1 down, bit 2 period buffering, bit 3 interrupt enable. While run is 0, `count` holds its value and no update event occurs.
- R3: The prescaler divides by (ratio+1). A write to address 1 only loads a holding register. The divider takes that value at the next update event, so the period in progress keeps the old ratio.
- R4: Counting upward, `count` runs 0,1,…,period. On the tick where `count` is greater than or equal to the period, it wraps to 0 with an update event. A full cycle lasts (period+1)·(ratio+1) clocks.
- R5: Counting downward, `count` runs period,…,1,0. On the tick at 0 it reloads the period with an update event.
- R6: A write to address 2 sets the period. With bit 2 of the control register clear, the new period applies at once. With bit 2 set, it applies only from the next update event.
- R7: `upd_evt` is high for exactly one clock, in the cycle after the edge where the counter wrapped or reloaded. In that cycle `count` already shows its restart value.
- R8: The status flag (address 4, bit 0) is set by every update event. A write to address 4 with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. An update in the same cycle as a clear wins.
- R9: `irq` is high exactly when the status flag is set and the interrupt enable bit is 1.
- R10: A write to address 3 loads `count` directly. It overrides any tick in that cycle and restarts the prescaler phase, so the next advance comes (ratio+1) clocks after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 ratio, 2 period, 3 count, 4 status) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| upd_evt | output | 1 | One-clock update event strobe |
| irq | output | 1 | Update interrupt request |

## Verification
The checker makes three assumptions about the inputs:
- `rst_n` is low for at least one edge.
- Each write lasts one cycle and targets one of the five decoded addresses.
- A count write in a cycle is the only reason the step properties stand aside; they are guarded on it.

The stimulus drives every write on the falling edge, one at a time, and uses only addresses 0 to 4. Before measuring, it lets at least one update event pass after each ratio change, so every measured period runs with a known divider ratio.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } tmr_state_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PSC  = 3'd1;
    localparam logic [ADDR_W-1:0] A_ARR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    localparam int B_RUN  = 0;
    localparam int B_DOWN = 1;
    localparam int B_BUF  = 2;
    localparam int B_IE   = 3;

endpackage

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       run_bit,
    input  logic       down_bit,
    output tmr_state_e state_q,
    output logic       run,
    output logic       down
);

    tmr_state_e state_d;
    tmr_state_e start_tgt;

    // Target state for a control write that asks to run.
    assign start_tgt = down_bit ? ST_DOWN : ST_UP;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (ctrl_wr && run_bit) state_d = start_tgt;      // START_UP / START_DOWN
            end
            ST_UP: begin
                if (ctrl_wr) state_d = run_bit ? start_tgt : ST_HALT;  // STOP / reverse
            end
            ST_DOWN: begin
                if (ctrl_wr) state_d = run_bit ? start_tgt : ST_HALT;  // STOP / reverse
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        run  = 1'b0;
        down = 1'b0;
        unique case (state_q)
            ST_HALT: begin run = 1'b0; down = 1'b0; end
            ST_UP:   begin run = 1'b1; down = 1'b0; end
            ST_DOWN: begin run = 1'b1; down = 1'b1; end
            default: begin run = 1'b0; down = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          buf_bit,
    input  logic          ie_bit,
    input  logic          psc_wr,
    input  logic [PW-1:0] psc_val,
    input  logic          arr_wr,
    input  logic [CW-1:0] arr_val,
    input  logic          stat_clr,
    input  logic          upd_now,
    output logic [PW-1:0] psc_sh,
    output logic [CW-1:0] arr_pre,
    output logic [CW-1:0] arr_eff,
    output logic          ie_q,
    output logic          flag_q
);

    logic          buf_q;
    logic [PW-1:0] psc_pre;
    logic [CW-1:0] arr_sh;

    // Unbuffered: the period written acts at once. Buffered: only the shadow counts.
    assign arr_eff = buf_q ? arr_sh : arr_pre;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (ctrl_wr) begin
            buf_q <= buf_bit;
            ie_q  <= ie_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_pre <= '0;
            psc_sh  <= '0;
        end else begin
            if (psc_wr)  psc_pre <= psc_val;
            if (upd_now) psc_sh  <= psc_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_pre <= '1;
            arr_sh  <= '1;
        end else begin
            if (arr_wr) arr_pre <= arr_val;
            if (!buf_q || upd_now) arr_sh <= arr_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (upd_now)  flag_q <= 1'b1;
        else if (stat_clr) flag_q <= 1'b0;
    end

endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          phase_clr,
    input  logic [PW-1:0] ratio,
    output logic          tick
);

    logic [PW-1:0] pcnt;

    assign tick = run && !phase_clr && (pcnt >= ratio);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pcnt <= '0;
        else if (phase_clr) pcnt <= '0;
        else if (tick)      pcnt <= '0;
        else if (run)       pcnt <= pcnt + PW'(1);
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          down,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_val,
    input  logic [CW-1:0] arr_eff,
    input  logic [CW-1:0] arr_pre,
    output logic [CW-1:0] count,
    output logic          upd_now,
    output logic          upd_evt
);

    logic at_end;

    assign at_end  = down ? (count == '0) : (count >= arr_eff);
    assign upd_now = tick && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (cnt_wr)  count <= cnt_val;
        else if (upd_now) count <= down ? arr_pre : '0;
        else if (tick)    count <= down ? count - CW'(1) : count + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_evt <= 1'b0;
        else        upd_evt <= upd_now;
    end

endmodule

// File: rtl/tmr_base.sv
module tmr_base
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [CW-1:0]     count,
    output logic              upd_evt,
    output logic              irq
);

    logic          ctrl_wr, psc_wr, arr_wr, cnt_wr, stat_wr, stat_clr;
    tmr_state_e    state_q;
    logic          run, down, tick, upd_now, ie_q, flag_q;
    logic [PW-1:0] psc_sh;
    logic [CW-1:0] arr_pre, arr_eff;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign psc_wr   = wr_en && (wr_addr == A_PSC);
    assign arr_wr   = wr_en && (wr_addr == A_ARR);
    assign cnt_wr   = wr_en && (wr_addr == A_CNT);
    assign stat_wr  = wr_en && (wr_addr == A_STAT);
    assign stat_clr = stat_wr && !wr_data[0];

    tmr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .run_bit  (wr_data[B_RUN]),
        .down_bit (wr_data[B_DOWN]),
        .state_q  (state_q),
        .run      (run),
        .down     (down)
    );

    tmr_regs #(.CW(CW), .PW(PW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .buf_bit  (wr_data[B_BUF]),
        .ie_bit   (wr_data[B_IE]),
        .psc_wr   (psc_wr),
        .psc_val  (wr_data[PW-1:0]),
        .arr_wr   (arr_wr),
        .arr_val  (wr_data[CW-1:0]),
        .stat_clr (stat_clr),
        .upd_now  (upd_now),
        .psc_sh   (psc_sh),
        .arr_pre  (arr_pre),
        .arr_eff  (arr_eff),
        .ie_q     (ie_q),
        .flag_q   (flag_q)
    );

    tmr_presc #(.PW(PW)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .phase_clr (cnt_wr),
        .ratio     (psc_sh),
        .tick      (tick)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .down    (down),
        .cnt_wr  (cnt_wr),
        .cnt_val (wr_data[CW-1:0]),
        .arr_eff (arr_eff),
        .arr_pre (arr_pre),
        .count   (count),
        .upd_now (upd_now),
        .upd_evt (upd_evt)
    );

    assign irq = flag_q && ie_q;

endmodule

// File: rtl/tmr_base_chk.sv
module tmr_base_chk
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input tmr_state_e    state_q,
    input logic          tick,
    input logic          cnt_wr,
    input logic          stat_clr,
    input logic          upd_now,
    input logic          upd_evt,
    input logic          flag_q,
    input logic [CW-1:0] count,
    input logic [CW-1:0] arr_eff,
    input logic [PW-1:0] psc_sh
);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !cnt_wr) |=> $stable(count));

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && tick && !cnt_wr && count < arr_eff)
        |=> count == $past(count) + CW'(1));

    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && tick && !cnt_wr && count != '0)
        |=> count == $past(count) - CW'(1));

    // R3
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_now |=> $stable(psc_sh));

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |-> flag_q);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !stat_clr) |=> flag_q);

endmodule

bind tmr_base tmr_base_chk #(.CW(CW), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .tick     (tick),
    .cnt_wr   (cnt_wr),
    .stat_clr (stat_clr),
    .upd_now  (upd_now),
    .upd_evt  (upd_evt),
    .flag_q   (flag_q),
    .count    (count),
    .arr_eff  (arr_eff),
    .psc_sh   (psc_sh)
);

// File: tb/tmr_base_bench.sv
module tmr_base_bench;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        upd_evt;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int unsigned cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_base u_tmr_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count   (count),
        .upd_evt (upd_evt),
        .irq     (irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_upd(string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_evt && n < 600);
        if (!upd_evt) chk({req, " update timeout"}, 0, 1);
    endtask

    function automatic logic [15:0] ctl(bit run, bit dn, bit bf, bit ie);
        return {12'd0, ie, bf, dn, run};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned t0;
        int v;
        repeat (3) @(negedge clk);
        chk("R1 count in reset", count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after reset", count, 0);
        chk("R1 upd_evt after reset", upd_evt, 0);
        chk("R1 irq after reset", irq, 0);
        repeat (10) @(negedge clk);
        chk("R1 halted after reset", count, 0);

        // R4 R5 R3 R7: sweep of direction, ratio and period
        for (int dn = 0; dn < 2; dn++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 6; a++) begin
                    int per;
                    string rq;
                    rq = (dn != 0) ? "R5 down count" : "R4 up count";
                    per = (a + 1) * (p + 1);
                    wr(A_CTRL, ctl(0, 0, 0, 0));
                    wr(A_PSC, 16'(p));
                    wr(A_ARR, 16'(a));
                    wr(A_CNT, 16'd0);
                    wr(A_CTRL, ctl(1, dn[0], 0, 0));
                    wait_upd("R7");
                    chk(rq, count, (dn != 0) ? a : 0);
                    for (int k = 1; k <= 2 * per; k++) begin
                        int q;
                        @(negedge clk);
                        q = (k % per) / (p + 1);
                        chk("R7 strobe", upd_evt, ((k % per) == 0) ? 1 : 0);
                        chk(rq, count, (dn != 0) ? (a - q) : q);
                    end
                end
            end
        end

        // R3: a new ratio waits for the next update event
        wr(A_CTRL, ctl(0, 0, 0, 0));
        wr(A_PSC, 16'd1);
        wr(A_ARR, 16'd3);
        wr(A_CNT, 16'd0);
        wr(A_CTRL, ctl(1, 0, 0, 0));
        wait_upd("R3");
        t0 = cyc;
        wr(A_PSC, 16'd3);
        wait_upd("R3");
        chk("R3 old ratio period", int'(cyc - t0), 8);
        t0 = cyc;
        wait_upd("R3");
        chk("R3 new ratio period", int'(cyc - t0), 16);

        // R10: count write and prescaler phase restart (ratio now 3)
        wr(A_CTRL, ctl(0, 0, 0, 0));
        wr(A_ARR, 16'd100);
        wr(A_CNT, 16'd10);
        chk("R10 count load", count, 10);
        wr(A_CTRL, ctl(1, 0, 0, 0));
        chk("R10 hold after start", count, 10);
        repeat (3) begin
            @(negedge clk);
            chk("R10 phase", count, 10);
        end
        @(negedge clk);
        chk("R10 first advance", count, 11);
        repeat (2) @(negedge clk);
        wr(A_CNT, 16'd50);
        chk("R10 load while running", count, 50);
        repeat (3) begin
            @(negedge clk);
            chk("R10 phase restart", count, 50);
        end
        @(negedge clk);
        chk("R10 advance after restart", count, 51);

        // R6: buffered period
        wr(A_CTRL, ctl(0, 0, 0, 0));
        wr(A_PSC, 16'd0);
        wr(A_ARR, 16'd4);
        wr(A_CNT, 16'd0);
        wr(A_CTRL, ctl(1, 0, 1, 0));
        wait_upd("R6");
        wait_upd("R6");
        t0 = cyc;
        wr(A_ARR, 16'd9);
        wait_upd("R6");
        chk("R6 buffered keeps old period", int'(cyc - t0), 5);
        t0 = cyc;
        wait_upd("R6");
        chk("R6 buffered new period", int'(cyc - t0), 10);

        // R6: immediate period
        wr(A_CTRL, ctl(1, 0, 0, 0));
        wr(A_ARR, 16'd4);
        wait_upd("R6");
        t0 = cyc;
        wr(A_ARR, 16'd9);
        wait_upd("R6");
        chk("R6 immediate period", int'(cyc - t0), 10);

        // R4: period lowered below the count wraps on the next tick
        wait_upd("R4");
        t0 = cyc;
        repeat (5) @(negedge clk);
        wr(A_ARR, 16'd2);
        wait_upd("R4");
        chk("R4 wrap when count above period", int'(cyc - t0), 7);
        t0 = cyc;
        wait_upd("R4");
        chk("R4 short period", int'(cyc - t0), 3);

        // R2: halted counter holds
        wr(A_CTRL, ctl(0, 0, 0, 0));
        v = count;
        repeat (20) begin
            @(negedge clk);
            chk("R2 halted count", count, v);
            chk("R2 halted no update", upd_evt, 0);
        end

        // R8 R9: flag and interrupt
        wr(A_STAT, 16'd0);
        wr(A_CTRL, ctl(0, 0, 0, 1));
        chk("R8 flag cleared", irq, 0);
        wr(A_CTRL, ctl(1, 0, 0, 0));
        wait_upd("R8");
        wr(A_CTRL, ctl(0, 0, 0, 0));
        chk("R9 masked irq", irq, 0);
        wr(A_CTRL, ctl(0, 0, 0, 1));
        chk("R9 irq on enable", irq, 1);
        wr(A_STAT, 16'd1);
        chk("R8 write one keeps flag", irq, 1);
        repeat (10) @(negedge clk);
        chk("R8 flag sticky", irq, 1);
        wr(A_STAT, 16'd0);
        chk("R8 write zero clears", irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule